// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode

This block is a first-in first-out buffer between two unrelated clock domains, nine bits wide and `DEPTH` words deep in its storage array. A writer on `wr_clk` pushes words and a reader on `rd_clk` pulls them. Each side keeps a Gray-coded pointer one bit wider than the address. Each pointer reaches the opposite domain through a two-stage synchronizer, and the flags there are compared directly from the synchronized copy.

A strap input is captured while the master reset is held, and it selects one of two read behaviours until the next reset. In standard mode, every word, including the first, must be requested with the read enable. In this mode the two flags are an active-low full flag and an active-low empty flag. In fall-through mode, the oldest word moves into the output register by itself, so the output register acts as one more storage slot. In this mode the flags become input-ready and output-ready. A half-full flag and a tri-state output bus complete the block.

Top module: `xclk_fifo`

## Requirements
- R1: After master reset, in standard mode (`mode_sel`=0) `full_flag` is 1 and `empty_flag` is 0. In fall-through mode (`mode_sel`=1) `full_flag` is 0 and `empty_flag` is 1. `half_n` is 1 in both modes, and the output register holds 0.
- R2: `mode_sel` is only captured during master reset. Changing it afterwards does not change the flag polarity or the read behaviour.
- R3: In standard mode, a rising `rd_clk` edge with `rd_en_n`=0 and the FIFO not empty loads the oldest word into the output register, so words leave in write order. With `rd_en_n`=1 the output keeps its value. A word written into an empty FIFO never reaches the output without a read request.
- R4: In standard mode, with no reads, `full_flag` goes to 0 on the `DEPTH`-th write. Writes attempted while full are dropped, and the stored words are unchanged.
- R5: A read request while the FIFO is empty does not change the output or the flags.
- R6: In fall-through mode, the first word written into an empty FIFO appears on `rd_data`, and `empty_flag` drops to 0, on the third rising `rd_clk` edge after the write edge, without any read request.
- R7: In fall-through mode, with no reads, `full_flag` (input-ready) stays 0 through `DEPTH` writes and becomes 1 on write `DEPTH`+1.
- R8: In fall-through mode, a read request while the output holds the last stored word sets `empty_flag` to 1 on that `rd_clk` edge. Later read requests leave `empty_flag` at 1 and the output unchanged.
- R9: After a read frees space in a full FIFO, the full condition clears on the second `wr_clk` edge after the read edge. After a write into an empty standard-mode FIFO, `empty_flag` rises on the second `rd_clk` edge after the write edge.
- R10: `half_n` falls when the array holds more than `DEPTH`/2 words, and it rises again once the array holds `DEPTH`/2 or fewer. It is lowered only by write-side logic and raised only by read-side logic.
- R11: With `out_en_n`=1 the bus does not carry the output register contents (high impedance). With `out_en_n`=0 it carries them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Master reset, asynchronous, active low |
| mode_sel | input | 1 | Mode strap captured during reset: 0 standard, 1 fall-through |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 9 | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | 9 | Output register contents, high impedance when disabled |
| full_flag | output | 1 | Standard: full, active low. Fall-through: input-ready, 1 = no room |
| empty_flag | output | 1 | Standard: empty, active low. Fall-through: output-ready, 1 = no word at output |
| half_n | output | 1 | Half-full, active low |

## Verification
The main function is tested with several distinct input patterns:
- A single word written into an empty FIFO shows the difference between the two modes. Standard mode keeps the output still, while fall-through mode presents the word on an exact read-clock edge.
- Filling to capacity, then writing once more, shows the extra slot that the output register adds in fall-through mode. The extra write also shows whether an over-full write corrupts the stored sequence.
- A single read from a full FIFO, and a single write into an empty one, are timed edge by edge against the two-stage flag latency.
- Reads issued on an empty FIFO, and a strap toggled after reset, separate real state changes from enables and straps that must be ignored.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/xclk_fifo_rst.sv
module xclk_fifo_rst (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/xclk_fifo_wr.sv
module xclk_fifo_wr #(
  parameter int AW   = 4,
  parameter int HALF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_n,
  input  logic [AW:0]   rgray_s,
  input  logic          rmark_s,
  output logic          wr_do,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          wmark
);
  logic [AW:0] wbin_q, wbin_d, wgray_d, rbin_s, fill;
  logic        over, wmark_d;

  always_comb begin
    full    = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    wr_do   = ~req_n & ~full;
    wbin_d  = wbin_q + (AW+1)'(wr_do);
    wgray_d = wbin_d ^ (wbin_d >> 1);
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
    fill    = wbin_q - rbin_s;
    over    = fill > (AW+1)'(HALF);
    wmark_d = wmark ^ (over & (wmark == rmark_s));
    waddr   = wbin_q[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
      wmark  <= 1'b0;
    end else begin
      if (wr_do) begin
        wbin_q <= wbin_d;
        wgray  <= wgray_d;
      end
      wmark <= wmark_d;
    end
  end
endmodule

// File: rtl/xclk_fifo_rd.sv
module xclk_fifo_rd #(
  parameter int AW   = 4,
  parameter int DW   = 9,
  parameter int HALF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          req_n,
  input  logic [AW:0]   wgray_s,
  input  logic          wmark_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          ov,
  output logic          rmark
);
  logic [AW:0] rbin_q, rbin_d, rgray_d, wbin_s, fill;
  logic        take, ov_d, over, rmark_d;

  always_comb begin
    empty   = (rgray == wgray_s);
    take    = fwft ? (~empty & (~ov | ~req_n)) : (~empty & ~req_n);
    ov_d    = fwft & (take | (ov & req_n));
    rbin_d  = rbin_q + (AW+1)'(take);
    rgray_d = rbin_d ^ (rbin_d >> 1);
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
    fill    = wbin_s - rbin_q;
    over    = fill > (AW+1)'(HALF);
    rmark_d = rmark ^ (~over & (rmark != wmark_s));
    raddr   = rbin_q[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q <= '0;
      rgray  <= '0;
      dout   <= '0;
      ov     <= 1'b0;
      rmark  <= 1'b0;
    end else begin
      if (take) begin
        rbin_q <= rbin_d;
        rgray  <= rgray_d;
        dout   <= mem_q;
      end
      ov    <= ov_d;
      rmark <= rmark_d;
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 16
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          full_flag,
  output logic          empty_flag,
  output logic          half_n
);
  localparam int AW   = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;

  logic          wr_rst_n, rd_rst_n;
  fifo_mode_e    mode_q;
  logic          is_fwft;
  logic          wr_do, arr_full, arr_empty, out_valid;
  logic          wmark, rmark, wmark_s, rmark_s;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem_q, dout;
  logic [DW-1:0] mem [DEPTH];

  xclk_fifo_rst u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n));
  xclk_fifo_rst u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

  // strap register: loads only while the read domain is held in reset
  always_ff @(posedge rd_clk) begin
    if (!rd_rst_n) mode_q <= fifo_mode_e'(mode_sel);
  end
  assign is_fwft = (mode_q == MODE_FWFT);

  xclk_fifo_sync #(.W(AW+2)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d({rmark, rgray}), .q({rmark_s, rgray_s})
  );
  xclk_fifo_sync #(.W(AW+2)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d({wmark, wgray}), .q({wmark_s, wgray_s})
  );

  xclk_fifo_wr #(.AW(AW), .HALF(HALF)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .req_n(wr_en_n), .rgray_s(rgray_s),
    .rmark_s(rmark_s), .wr_do(wr_do), .waddr(waddr), .wgray(wgray),
    .full(arr_full), .wmark(wmark)
  );

  xclk_fifo_rd #(.AW(AW), .DW(DW), .HALF(HALF)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .fwft(is_fwft), .req_n(rd_en_n),
    .wgray_s(wgray_s), .wmark_s(wmark_s), .mem_q(mem_q), .raddr(raddr),
    .rgray(rgray), .dout(dout), .empty(arr_empty), .ov(out_valid),
    .rmark(rmark)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_do) mem[waddr] <= wr_data;
  end
  assign mem_q = mem[raddr];

  assign full_flag  = is_fwft ? arr_full : ~arr_full;
  assign empty_flag = is_fwft ? ~out_valid : ~arr_empty;
  assign half_n     = ~(wmark ^ rmark);
  assign rd_data    = out_en_n ? {DW{1'bz}} : dout;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int AW = 4
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        wr_rst_n,
  input logic        rd_rst_n,
  input logic        is_fwft,
  input logic        wr_en_n,
  input logic        rd_en_n,
  input logic        arr_full,
  input logic        arr_empty,
  input logic        out_valid,
  input logic        empty_flag,
  input logic [AW:0] wgray,
  input logic [AW:0] rgray
);
  assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (arr_full && !wr_en_n) |=> $stable(wgray));

  assert_wptr_gray_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!is_fwft && arr_empty && !rd_en_n) |=> $stable(rgray));

  assert_rptr_gray_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_last_read_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (is_fwft && out_valid && arr_empty && !rd_en_n) |=> empty_flag);

  assert_mode_hold_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $stable(is_fwft));
endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .is_fwft(is_fwft), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .arr_full(arr_full),
  .arr_empty(arr_empty), .out_valid(out_valid), .empty_flag(empty_flag),
  .wgray(wgray), .rgray(rgray)
);

// File: tb/xclk_fifo_test.sv
module xclk_fifo_test;
  localparam int DW = 9;
  localparam int D  = 16;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic rst_n, mode_sel, wr_en_n, rd_en_n, out_en_n;
  logic [DW-1:0] wr_data;
  wire  [DW-1:0] rd_data;
  wire  full_flag, empty_flag, half_n;
  int checks = 0, errors = 0;

  always #5 wr_clk = ~wr_clk;   // 100 MHz, rising edges at odd ns
  always #6 rd_clk = ~rd_clk;   // rising edges at even ns, never coincident

  xclk_fifo #(.DW(DW), .DEPTH(D)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .out_en_n(out_en_n),
    .rd_data(rd_data), .full_flag(full_flag), .empty_flag(empty_flag), .half_n(half_n)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(logic m);
    rst_n = 1'b0; mode_sel = m; wr_en_n = 1'b1; rd_en_n = 1'b1;
    out_en_n = 1'b0; wr_data = '0;
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk) rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    repeat (3) @(negedge wr_clk);
  endtask

  task automatic push(logic [DW-1:0] d);
    @(negedge wr_clk) begin wr_en_n = 1'b0; wr_data = d; end
    @(negedge wr_clk) wr_en_n = 1'b1;
  endtask

  task automatic pop;
    @(negedge rd_clk) rd_en_n = 1'b0;
    @(negedge rd_clk) rd_en_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk("R1", "std full_flag", 16'(full_flag), 16'h1);
    chk("R1", "std empty_flag", 16'(empty_flag), 16'h0);
    chk("R1", "half_n", 16'(half_n), 16'h1);
    chk("R1", "output reg", 16'(rd_data), 16'h0);
    do_reset(1'b1);
    chk("R1", "fwft input-ready", 16'(full_flag), 16'h0);
    chk("R1", "fwft output-ready", 16'(empty_flag), 16'h1);
  endtask

  task automatic t_std_basic;
    do_reset(1'b0);
    pop;                                   // R5: read on empty
    chk("R5", "q after empty read", 16'(rd_data), 16'h0);
    chk("R5", "EF after empty read", 16'(empty_flag), 16'h0);
    @(negedge wr_clk) begin wr_en_n = 1'b0; wr_data = 9'h1A5; end
    @(posedge wr_clk);
    fork
      begin @(negedge wr_clk) wr_en_n = 1'b1; end
      begin                                // R9: empty flag latency
        @(posedge rd_clk); @(negedge rd_clk);
        chk("R9", "EF after 1 rd edge", 16'(empty_flag), 16'h0);
        @(posedge rd_clk); @(negedge rd_clk);
        chk("R9", "EF after 2 rd edges", 16'(empty_flag), 16'h1);
      end
    join
    repeat (5) @(negedge rd_clk);
    chk("R3", "no fall-through in std", 16'(rd_data), 16'h0);
    push(9'h011); push(9'h022);
    pop; chk("R3", "first word", 16'(rd_data), 16'h1A5);
    repeat (6) @(negedge rd_clk);
    chk("R3", "hold with rd_en_n high", 16'(rd_data), 16'h1A5);
    pop; chk("R3", "second word", 16'(rd_data), 16'h011);
    out_en_n = 1'b1; #1;
    checks++;
    if (rd_data === 9'h011) begin
      errors++;
      $display("FAIL R11: disabled bus actual=%h expected=not %h", rd_data, 9'h011);
    end
    out_en_n = 1'b0; #1;
    chk("R11", "enabled bus", 16'(rd_data), 16'h011);
    pop; chk("R3", "third word", 16'(rd_data), 16'h022);
    chk("R3", "EF after draining", 16'(empty_flag), 16'h0);
  endtask

  task automatic t_std_full;
    do_reset(1'b0);
    for (int i = 0; i < D - 1; i++) push(9'(9'h040 + i));
    chk("R4", "FF before last write", 16'(full_flag), 16'h1);
    push(9'(9'h040 + D - 1));
    chk("R4", "FF after D writes", 16'(full_flag), 16'h0);
    push(9'h1FF);                          // dropped
    @(negedge rd_clk) rd_en_n = 1'b0;
    @(posedge rd_clk);
    fork
      begin @(negedge rd_clk) rd_en_n = 1'b1; end
      begin                                // R9: full flag latency
        @(posedge wr_clk); @(negedge wr_clk);
        chk("R9", "FF after 1 wr edge", 16'(full_flag), 16'h0);
        @(posedge wr_clk); @(negedge wr_clk);
        chk("R9", "FF after 2 wr edges", 16'(full_flag), 16'h1);
      end
    join
    chk("R4", "word 0", 16'(rd_data), 16'h040);
    for (int i = 1; i < D; i++) begin
      pop; chk("R4", "stored word", 16'(rd_data), 16'(9'h040 + i));
    end
    chk("R4", "empty after D reads", 16'(empty_flag), 16'h0);
    pop;
    chk("R5", "q kept after extra read", 16'(rd_data), 16'(9'h040 + D - 1));
  endtask

  task automatic t_half;
    do_reset(1'b0);
    for (int i = 0; i < D / 2; i++) push(9'(i));
    repeat (6) @(negedge rd_clk);
    chk("R10", "half_n at D/2", 16'(half_n), 16'h1);
    push(9'h0AB);
    repeat (4) @(negedge wr_clk);
    chk("R10", "half_n above D/2", 16'(half_n), 16'h0);
    pop;
    repeat (6) @(negedge rd_clk);
    chk("R10", "half_n back at D/2", 16'(half_n), 16'h1);
  endtask

  task automatic t_fwft;
    do_reset(1'b1);
    @(negedge wr_clk) begin wr_en_n = 1'b0; wr_data = 9'h155; end
    @(posedge wr_clk);
    fork
      begin @(negedge wr_clk) wr_en_n = 1'b1; end
      begin
        @(posedge rd_clk); @(negedge rd_clk);
        chk("R6", "OR after edge 1", 16'(empty_flag), 16'h1);
        @(posedge rd_clk); @(negedge rd_clk);
        chk("R6", "OR after edge 2", 16'(empty_flag), 16'h1);
        @(posedge rd_clk); @(negedge rd_clk);
        chk("R6", "OR after edge 3", 16'(empty_flag), 16'h0);
        chk("R6", "q after edge 3", 16'(rd_data), 16'h155);
      end
    join
    repeat (4) @(negedge wr_clk);
    for (int i = 0; i < D - 1; i++) push(9'(9'h060 + i));
    chk("R7", "IR low after D writes", 16'(full_flag), 16'h0);
    push(9'(9'h060 + D - 1));
    chk("R7", "IR high after D+1 writes", 16'(full_flag), 16'h1);
    push(9'h0AA);                          // dropped
    chk("R8", "head word", 16'(rd_data), 16'h155);
    for (int i = 0; i < D; i++) begin
      pop;
      chk("R8", "OR while words remain", 16'(empty_flag), 16'h0);
      chk("R8", "next word", 16'(rd_data), 16'(9'h060 + i));
    end
    pop;
    chk("R8", "OR after last true read", 16'(empty_flag), 16'h1);
    pop;
    chk("R8", "OR stays high", 16'(empty_flag), 16'h1);
    chk("R8", "q unchanged", 16'(rd_data), 16'(9'h060 + D - 1));
  endtask

  task automatic t_strap;
    do_reset(1'b0);
    mode_sel = 1'b1;
    push(9'h0C3);
    repeat (6) @(negedge rd_clk);
    chk("R2", "std EF polarity kept", 16'(empty_flag), 16'h1);
    chk("R2", "no fall-through", 16'(rd_data), 16'h0);
    chk("R2", "std FF polarity kept", 16'(full_flag), 16'h1);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_std_basic;
        t_std_full;
        t_half;
        t_fwft;
        t_strap;
      end
      begin
        repeat (100000) @(posedge wr_clk);
        errors++;
        $display("FAIL watchdog: run actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule